// File: doc/BRIEF.md
# Self-Synchronizing Disk Nibble Shift Register

This block turns the serial bit stream from a floppy read channel into 8-bit nibbles. It has no bit counter. A new nibble begins with the first one-bit that enters an empty register. The nibble is complete as soon as a one-bit reaches the top position. Software polls the register and treats a set top bit as "data valid". Zero-bits that arrive while the register is empty are absorbed, so padding zeros between nibbles do not change the decoded values.

A status-load strobe puts a status word into the register. The word stays readable for a short window, and then the register is forced to zero. Every bit cell that ends during that window is lost, and any partial nibble is lost with it. Framing then restarts from the next one-bit. Software uses this to shift the framing on purpose: the same bits on disk decode to different values depending on when the load is issued.

The drive enable follows motor commands. After a motor-off command it stays active for a fixed hold count. While the enable is low, the bit clock stops and the register value stays frozen.

The read port is a one-way stream with no back-pressure. A strobe on `reg_read` returns the register value one cycle later on `read_data`, with `read_valid` high for one cycle. A disk cannot pause, so there is no ready input.

Top module: `selfsync_nibble_rx`

## Requirements
- R1: While reset is low, `reg_value` is 0x00, `drive_en` is 0 and `read_valid` is 0.
- R2: While `drive_en` is high, one bit of `cell_bit` is sampled every CELL_CYC cycles. The first sample is on the CELL_CYC-th rising edge after the edge that raised `drive_en`. A zero sample into an all-zero register leaves it at zero. A sample into a partly assembled register shifts it left, with the new bit entering bit 0.
- R3: When bit 7 of `reg_value` becomes 1, the nibble is complete. Its value then stays unchanged for HOLD_CYC cycles.
- R4: After the hold window of a completed nibble, a sampled one-bit makes `reg_value` 0x01 (a new nibble starts). A sampled zero-bit leaves the completed value in place.
- R5: A `status_load` pulse copies `status_word` into `reg_value` on that edge. The value stays there for HOLD_CYC cycles, and on the next edge the register becomes 0x00. Every bit sampled from the load edge through the clear edge is discarded. Assembly then restarts from the next one-bit.
- R6: When a status load and a bit sample fall on the same edge, the status load wins and the sampled bit is discarded.
- R7: A `motor_on` pulse makes `drive_en` high from the next cycle. After a `motor_off` pulse, `drive_en` stays high for exactly MOTOR_HOLD cycles and then drops. A `motor_on` pulse inside that window cancels the drop.
- R8: While `drive_en` is low and no status load occurs, `reg_value` does not change, whatever `cell_bit` does.
- R9: A `reg_read` pulse gives `read_valid` = 1 on the next cycle, with `read_data` equal to the register value at the strobe edge. The read does not change `reg_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the CPU cycle rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_bit | input | 1 | Serial read bit, held for one bit cell |
| reg_read | input | 1 | Data register read strobe |
| status_load | input | 1 | Load status word and desynchronise |
| status_word | input | 8 | Status bits copied on a status load |
| motor_on | input | 1 | Motor start command pulse |
| motor_off | input | 1 | Motor stop command pulse |
| reg_value | output | 8 | Live data register value |
| read_data | output | 8 | Value returned for a read strobe |
| read_valid | output | 1 | One-cycle pulse qualifying `read_data` |
| drive_en | output | 1 | Drive enable |

## Verification
The per-cycle assertions cover the local rules of the register:
- a completed nibble stays stable through its hold window;
- an empty register absorbs zeros;
- a one-bit after the hold window restarts at 0x01;
- a status load wins the cycle;
- the register stays frozen while the drive is disabled;
- the read returns its value and drive enable is held after a motor command.

Framing is a property of the whole stream, so only the bench scenarios show it. They check that a padded stream decodes to the expected nibbles. They also check that a status load issued at chosen cycle offsets drops exactly the covered bit cells and produces the shifted decoding that the remaining bits imply.

// File: rtl/sns_pkg.sv
package sns_pkg;
  localparam int NIB_W = 8;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/sns_cell_timer.sv
module sns_cell_timer #(
  parameter int CELL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sample
);
  localparam int CW = (CELL_CYC > 1) ? $clog2(CELL_CYC) : 1;
  logic [CW-1:0] cnt_q;

  assign sample = run && (cnt_q == CW'(CELL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (sample)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  // R2
  sample_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sample);
endmodule

// File: rtl/sns_motor_hold.sv
module sns_motor_hold #(
  parameter int MOTOR_HOLD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic enable
);
  localparam int MW = $clog2(MOTOR_HOLD + 1);
  logic [MW-1:0] left_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      pend_q <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      enable <= 1'b1;
      pend_q <= 1'b0;
    end else if (stop && enable) begin
      pend_q <= 1'b1;
      left_q <= MW'(MOTOR_HOLD - 1);
    end else if (pend_q) begin
      if (left_q == '0) begin
        enable <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        left_q <= left_q - MW'(1);
      end
    end
  end

  // R7
  start_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> enable);
  // R7
  hold_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && left_q != '0) |=> enable);
endmodule

// File: rtl/sns_nibble_reg.sv
module sns_nibble_reg
  import sns_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic bit_in,
  input  logic load,
  input  nib_t load_val,
  output nib_t q
);
  localparam int AW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  logic [AW-1:0] age_q;
  logic          stat_q;
  logic          expired;

  assign expired = (age_q == AW'(HOLD_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      stat_q <= 1'b0;
      age_q  <= '0;
    end else begin
      if (!expired) age_q <= age_q + AW'(1);
      if (load) begin
        q      <= load_val;
        stat_q <= 1'b1;
        age_q  <= '0;
      end else if (stat_q) begin
        if (expired) begin
          q      <= '0;
          stat_q <= 1'b0;
        end
      end else if (sample) begin
        if (q == '0) begin
          q <= nib_t'(bit_in);
        end else if (q[NIB_W-1]) begin
          if (expired && bit_in) q <= nib_t'(1);
        end else begin
          q <= {q[NIB_W-2:0], bit_in};
          if (q[NIB_W-2]) age_q <= '0;
        end
      end
    end
  end

  // R2
  zero_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '0 && !stat_q && !load && sample && !bit_in) |=> (q == '0));
  // R3
  nibble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[NIB_W-1] && !stat_q && !load && !expired) |=> $stable(q));
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[NIB_W-1] && !stat_q && !load && expired && sample && bit_in) |=> (q == nib_t'(1)));
  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));
  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sample) |=> (q == $past(load_val)));
  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !load && !stat_q && (q == '0 || !q[NIB_W-1])) |=> $stable(q));
endmodule

// File: rtl/selfsync_nibble_rx.sv
module selfsync_nibble_rx
  import sns_pkg::*;
#(
  parameter int CELL_CYC   = 4,
  parameter int HOLD_CYC   = 4,
  parameter int MOTOR_HOLD = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_bit,
  input  logic       reg_read,
  input  logic       status_load,
  input  logic [7:0] status_word,
  input  logic       motor_on,
  input  logic       motor_off,
  output logic [7:0] reg_value,
  output logic [7:0] read_data,
  output logic       read_valid,
  output logic       drive_en
);
  logic sample;
  nib_t q;

  sns_motor_hold #(.MOTOR_HOLD(MOTOR_HOLD)) u_motor (
    .clk(clk), .rst_n(rst_n), .start(motor_on), .stop(motor_off), .enable(drive_en)
  );

  sns_cell_timer #(.CELL_CYC(CELL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(drive_en), .sample(sample)
  );

  sns_nibble_reg #(.HOLD_CYC(HOLD_CYC)) u_nib (
    .clk(clk), .rst_n(rst_n), .sample(sample), .bit_in(cell_bit),
    .load(status_load), .load_val(status_word), .q(q)
  );

  assign reg_value = q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      read_valid <= 1'b0;
      read_data  <= '0;
    end else begin
      read_valid <= reg_read;
      if (reg_read) read_data <= q;
    end
  end

  // R9
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_read |=> (read_valid && read_data == $past(reg_value)));
  // R8
  disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_en && !status_load && !$past(status_load)) |=> (reg_value == $past(reg_value) || reg_value == '0));
endmodule

// File: tb/selfsync_nibble_rx_tb.sv
`timescale 1ns/1ps
module selfsync_nibble_rx_tb;
  localparam int CELL = 4;
  localparam int HOLD = 4;
  localparam int MH   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_bit = 1'b0, reg_read = 1'b0, status_load = 1'b0;
  logic [7:0] status_word = 8'h00;
  logic motor_on = 1'b0, motor_off = 1'b0;
  logic [7:0] reg_value, read_data;
  logic read_valid, drive_en;

  always #2.5 clk = ~clk;

  selfsync_nibble_rx #(.CELL_CYC(CELL), .HOLD_CYC(HOLD), .MOTOR_HOLD(MH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cell_bit(cell_bit), .reg_read(reg_read),
    .status_load(status_load), .status_word(status_word), .motor_on(motor_on),
    .motor_off(motor_off), .reg_value(reg_value), .read_data(read_data),
    .read_valid(read_valid), .drive_en(drive_en)
  );

  int n_chk = 0, n_bad = 0;
  bit bits [0:255];
  int nbits;
  logic [7:0] exp_q [0:63];
  int exp_n;
  logic [7:0] got_q [0:63];
  int got_n;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cell_bit = 1'b0; status_load = 1'b0; reg_read = 1'b0;
    motor_on = 1'b0; motor_off = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ends on the negedge right after the edge that sampled motor_on
  task automatic start_motor();
    @(negedge clk); motor_on = 1'b1;
    @(negedge clk); motor_on = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b, input int gap);
    for (int i = 7; i >= 0; i--) begin bits[nbits] = b[i]; nbits++; end
    for (int g = 0; g < gap; g++) begin bits[nbits] = 1'b0; nbits++; end
  endtask

  task automatic build_stream();
    nbits = 0;
    push_byte(8'hD5, 1); push_byte(8'hE7, 2); push_byte(8'hE7, 0);
    push_byte(8'hE7, 1); push_byte(8'hE7, 2); push_byte(8'hE7, 0);
    push_byte(8'hE7, 1); push_byte(8'hE7, 1); push_byte(8'hE7, 2);
    push_byte(8'hE7, 0); push_byte(8'hE7, 3);
  endtask

  // decode from bit start; nibbles completing at or after stop_edge are lost
  task automatic decode_seg(input int start, input int stop_edge);
    int k = start;
    while (k + 8 <= nbits) begin
      if (!bits[k]) k++;
      else begin
        logic [7:0] v;
        if (stop_edge > 0 && CELL * (k + 8) >= stop_edge) return;
        for (int i = 0; i < 8; i++) v[7-i] = bits[k+i];
        exp_q[exp_n] = v; exp_n++;
        k += 8;
      end
    end
  endtask

  task automatic build_exp(input int ld_c);
    exp_n = 0;
    decode_seg(0, ld_c);
    if (ld_c > 0) begin
      int k0 = 0;
      while (CELL * (k0 + 1) <= ld_c + HOLD) k0++;
      decode_seg(k0, 0);
    end
  endtask

  task automatic run_stream(input int ld_c, input logic [7:0] sw, input string req);
    bit prev7 = 1'b0;
    int hold_left = 0;
    logic [7:0] held = 8'h00;
    build_exp(ld_c);
    got_n = 0;
    do_reset();
    start_motor();
    for (int c = 1; c <= CELL * nbits + 1; c++) begin
      int cp = c - 1;
      logic [7:0] v;
      bit in_stat;
      if (c > 1) @(negedge clk);
      v = reg_value;
      in_stat = (ld_c > 0) && cp >= ld_c && cp <= ld_c + HOLD;
      if (ld_c > 0 && (cp == ld_c || cp == ld_c + HOLD - 1))
        chk(v == sw, "R5", "status word visible", v, sw);
      if (ld_c > 0 && cp == ld_c + HOLD)
        chk(v == 8'h00, "R5", "forced clear after window", v, 0);
      if (hold_left > 0 && !(ld_c > 0 && cp >= ld_c)) begin
        chk(v == held, "R3", "nibble held", v, held);
        hold_left--;
      end
      if (!in_stat && v[7] && !prev7) begin
        if (got_n < 64) begin got_q[got_n] = v; got_n++; end
        held = v; hold_left = HOLD - 1;
      end
      prev7 = v[7];
      if (c <= CELL * nbits) begin
        cell_bit = bits[(c-1)/CELL];
        status_load = (c == ld_c);
        status_word = sw;
      end
    end
    status_load = 1'b0;
    cell_bit = 1'b0;
    chk(got_n == exp_n, req, "nibble count", got_n, exp_n);
    for (int i = 0; i < got_n && i < exp_n; i++)
      chk(got_q[i] == exp_q[i], req, "decoded nibble", got_q[i], exp_q[i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(reg_value == 8'h00, "R1", "reg_value in reset", reg_value, 0);
    chk(drive_en == 1'b0, "R1", "drive_en in reset", drive_en, 0);
    chk(read_valid == 1'b0, "R1", "read_valid in reset", read_valid, 0);
  endtask

  task automatic t_plain();
    build_stream();
    run_stream(0, 8'h00, "R2_R4");
  endtask

  task automatic t_desync();
    build_stream();
    run_stream(50, 8'h2A, "R5");
    run_stream(80, 8'h15, "R6");
    run_stream(123, 8'h3C, "R5");
  endtask

  task automatic t_motor_and_read();
    logic [7:0] v;
    do_reset();
    start_motor();
    cell_bit = 1'b1;
    repeat (10) @(negedge clk);
    motor_off = 1'b1;
    @(negedge clk); motor_off = 1'b0;
    chk(drive_en == 1'b1, "R7", "enable right after stop", drive_en, 1);
    for (int d = 1; d <= MH; d++) begin
      @(negedge clk);
      cell_bit = ~cell_bit;
      if (d == MH - 1) chk(drive_en == 1'b1, "R7", "enable at end of hold", drive_en, 1);
      if (d == MH)     chk(drive_en == 1'b0, "R7", "enable dropped", drive_en, 0);
    end
    v = reg_value;
    for (int i = 0; i < 24; i++) begin @(negedge clk); cell_bit = ~cell_bit; end
    chk(reg_value == v, "R8", "frozen while disabled", reg_value, v);
    reg_read = 1'b1;
    @(negedge clk); reg_read = 1'b0;
    chk(read_valid == 1'b1, "R9", "read_valid pulse", read_valid, 1);
    chk(read_data == v, "R9", "read_data value", read_data, v);
    chk(reg_value == v, "R9", "read leaves register", reg_value, v);
    @(negedge clk);
    chk(read_valid == 1'b0, "R9", "read_valid single cycle", read_valid, 0);
    cell_bit = 1'b0;
    start_motor();
    motor_off = 1'b1;
    @(negedge clk); motor_off = 1'b0;
    repeat (MH / 2) @(negedge clk);
    start_motor();
    repeat (MH + 4) @(negedge clk);
    chk(drive_en == 1'b1, "R7", "restart cancels drop", drive_en, 1);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_desync();
    t_motor_and_read();
    summary();
    $finish;
  end
endmodule